// File: doc/BRIEF.md
# Vectored Chained Transfer Controller

This controller moves data between memory locations on behalf of peripherals or software, without the CPU touching each item. A peripheral raises an activation flag; if that source's enable bit is set, the controller reads a start pointer from a vector table. It then fetches a five-word transfer record from that pointer and performs one byte or word move. The updated addresses and counter are written back into the record. Software can start the same sequence for any vector number through a trigger input.

A record may point onward to the next record, placed directly after it in memory. All linked records run inside one activation. The last record decides how the activation ends. Before the count is exhausted, the controller clears the activating flag. When a normal-mode count reaches zero, it leaves the flag set, drops the source's enable bit and pulses an interrupt so the CPU can finish the job.

Record layout, at byte offsets from the record pointer: +0 mode word, +2 link word, +4 source address, +6 destination address, +8 count. Mode word bits: [15:14] source step, [13:12] destination step, [11:10] transfer mode, [9] repeat side (1 = source), [8] size (1 = word). Link word bit [15] is the link bit. Memory words are stored high byte first, at even addresses.

Top module: `vdma_ctrl`

## Requirements
- R1: The record pointer for vector number V is read from address 0x0400 + 2*V; hardware source i uses vector 0x20 + i.
- R2: A step field value of 2'b10 increments the address after the move, 2'b11 decrements it, and 2'b00 or 2'b01 holds it. This applies independently to source and destination.
- R3: Size bit 1 moves a 16-bit word and steps by 2. Size bit 0 moves one byte, carried on data bits [7:0], and steps by 1.
- R4: In normal mode (mode field 2'b00), each move writes back the stepped source and destination addresses and the count minus one into the record.
- R5: In repeat mode (mode field 2'b01), only the low count byte decrements. When it reaches zero, it is reloaded from the high count byte, and the address on the repeat side returns to its starting value.
- R6: When the link bit is 1, the record at the pointer plus 10 is fetched and executed within the same activation.
- R7: After the last record of an activation, if its count did not end, the controller pulses `src_clr` for the activating source, one-hot. An earlier linked record whose count ends has no effect on the flag, the enable or the interrupt.
- R8: When a last record in normal mode counts down to zero, `done_irq` pulses once with `done_vec` equal to the vector. For a hardware source, the flag is left set and its enable bit is cleared.
- R9: Among set flags whose enable bit is 1, the lowest source index is served first. A flag whose enable bit is 0 is never served.
- R10: A `sw_req` pulse activates the vector on `sw_vec`. If the controller is busy, the request is held and served after the current activation ends.
- R11: `busy` is high from the vector read to the completion cycle: 13 cycles for one record, plus 10 for each linked record. No memory request is made while idle.
- R12: After reset, `busy`, `mem_req`, `done_irq`, `src_clr` and every enable bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | N_SRC | Activation flags from peripherals |
| src_clr | output | N_SRC | One-cycle pulse clearing a peripheral flag |
| en_wr | input | 1 | Load the enable bits |
| en_wdata | input | N_SRC | Enable bit values to load |
| src_en | output | N_SRC | Current per-source enable bits |
| sw_req | input | 1 | Software activation pulse |
| sw_vec | input | 8 | Vector number for software activation |
| busy | output | 1 | An activation is in progress |
| done_irq | output | 1 | End-of-count interrupt pulse |
| done_vec | output | 8 | Vector of the finished activation |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_wide | output | 1 | Access is a word (1) or a byte (0) |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |

## Verification
The assertions check the following on every cycle:
- the memory port stays quiet while idle;
- every activation opens with a read inside the vector table;
- flag clears are one-hot and only go to enabled sources;
- the completion interrupt never comes with a flag clear;
- an enable bit only drops together with a completion interrupt.

Only the bench's scenarios can show the rest:
- the data values moved and the written-back addresses for each step and size combination;
- the repeat-area reload;
- link traversal within one activation;
- the service order among competing flags;
- that a software request made while busy is held.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_VEC, S_PTR, S_FETCH, S_RD, S_WR, S_WB0, S_WB1, S_WB2, S_DONE
    } st_e;
endpackage

// File: rtl/vdma_arb.sv
module vdma_arb #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/vdma_step.sv
module vdma_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    amode,
    input  logic          wide,
    input  logic          reload,
    input  logic [7:0]    span_cnt,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] step, span;

    always_comb begin
        step = wide ? AW'(2) : AW'(1);
        span = wide ? AW'({span_cnt, 1'b0}) : AW'(span_cnt);
        unique case (amode)
            2'b10:   nxt = reload ? (addr + step - span) : (addr + step);
            2'b11:   nxt = reload ? (addr - step + span) : (addr - step);
            default: nxt = addr;
        endcase
    end
endmodule

// File: rtl/vdma_ctrl.sv
module vdma_ctrl
    import vdma_pkg::*;
#(
    parameter int          N_SRC     = 4,
    parameter logic [7:0]  VEC_BASE  = 8'h20,
    parameter logic [15:0] VTAB_BASE = 16'h0400,
    parameter logic [15:0] REC_BYTES = 16'd10,
    localparam int         SW        = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_src,
    output logic [N_SRC-1:0] src_clr,
    input  logic             en_wr,
    input  logic [N_SRC-1:0] en_wdata,
    output logic [N_SRC-1:0] src_en,
    input  logic             sw_req,
    input  logic [7:0]       sw_vec,
    output logic             busy,
    output logic             done_irq,
    output logic [7:0]       done_vec,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_wide,
    output logic [15:0]      mem_addr,
    output logic [15:0]      mem_wdata,
    input  logic [15:0]      mem_rdata
);
    typedef struct packed {
        st_e              st;
        logic [2:0]       idx;
        logic [7:0]       vec;
        logic             sw;
        logic [SW-1:0]    src;
        logic [15:0]      ptr;
        logic [15:0]      mode;
        logic [15:0]      sar;
        logic [15:0]      dar;
        logic [15:0]      cnt;
        logic             chain;
        logic             fin;
        logic [N_SRC-1:0] en;
        logic             swp;
        logic [7:0]       swv;
    } regs_t;

    regs_t q, d;

    logic          hw_v;
    logic [SW-1:0] hw_i;
    logic [15:0]   sar_nx, dar_nx, cnt_nx;
    logic          rpt, wrap, fin_nx;
    logic [7:0]    lo_m;

    vdma_arb #(.N(N_SRC)) u_arb (
        .req   (irq_src & q.en),
        .valid (hw_v),
        .idx   (hw_i)
    );

    always_comb begin
        rpt    = (q.mode[11:10] == 2'b01);
        lo_m   = q.cnt[7:0] - 8'd1;
        wrap   = rpt && (lo_m == 8'd0);
        cnt_nx = rpt ? {q.cnt[15:8], (wrap ? q.cnt[15:8] : lo_m)} : (q.cnt - 16'd1);
        fin_nx = !rpt && (q.cnt == 16'd1);
    end

    vdma_step #(.AW(16)) u_src_step (
        .addr (q.sar), .amode (q.mode[15:14]), .wide (q.mode[8]),
        .reload (wrap && q.mode[9]), .span_cnt (q.cnt[15:8]), .nxt (sar_nx)
    );

    vdma_step #(.AW(16)) u_dst_step (
        .addr (q.dar), .amode (q.mode[13:12]), .wide (q.mode[8]),
        .reload (wrap && !q.mode[9]), .span_cnt (q.cnt[15:8]), .nxt (dar_nx)
    );

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wide  = 1'b1;
        mem_addr  = '0;
        mem_wdata = '0;
        src_clr   = '0;
        done_irq  = 1'b0;
        if (sw_req) begin
            d.swp = 1'b1;
            d.swv = sw_vec;
        end
        unique case (q.st)
            S_IDLE: begin
                if (hw_v) begin
                    d.vec = VEC_BASE + 8'(hw_i);
                    d.sw  = 1'b0;
                    d.src = hw_i;
                    d.st  = S_VEC;
                end else if (q.swp) begin
                    d.vec = q.swv;
                    d.sw  = 1'b1;
                    d.swp = sw_req;
                    d.st  = S_VEC;
                end
            end
            S_VEC: begin
                mem_req  = 1'b1;
                mem_addr = VTAB_BASE + {7'd0, q.vec, 1'b0};
                d.st     = S_PTR;
            end
            S_PTR: begin
                d.ptr = mem_rdata;
                d.idx = '0;
                d.st  = S_FETCH;
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.ptr + 16'({q.idx, 1'b0});
                unique case (q.idx)
                    3'd1:    d.mode  = mem_rdata;
                    3'd2:    d.chain = mem_rdata[15];
                    3'd3:    d.sar   = mem_rdata;
                    3'd4:    d.dar   = mem_rdata;
                    default: ;
                endcase
                if (q.idx == 3'd4) d.st  = S_RD;
                else               d.idx = q.idx + 3'd1;
            end
            S_RD: begin
                d.cnt    = mem_rdata;
                mem_req  = 1'b1;
                mem_wide = q.mode[8];
                mem_addr = q.sar;
                d.st     = S_WR;
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wide  = q.mode[8];
                mem_addr  = q.dar;
                mem_wdata = q.mode[8] ? mem_rdata : {8'd0, mem_rdata[7:0]};
                d.sar     = sar_nx;
                d.dar     = dar_nx;
                d.cnt     = cnt_nx;
                d.fin     = fin_nx;
                d.st      = S_WB0;
            end
            S_WB0: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = q.ptr + 16'd4; mem_wdata = q.sar;
                d.st = S_WB1;
            end
            S_WB1: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = q.ptr + 16'd6; mem_wdata = q.dar;
                d.st = S_WB2;
            end
            S_WB2: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = q.ptr + 16'd8; mem_wdata = q.cnt;
                if (q.chain) begin
                    d.ptr = q.ptr + REC_BYTES;
                    d.idx = '0;
                    d.st  = S_FETCH;
                end else begin
                    d.st = S_DONE;
                end
            end
            S_DONE: begin
                if (q.fin) begin
                    done_irq = 1'b1;
                    if (!q.sw) d.en[q.src] = 1'b0;
                end else if (!q.sw) begin
                    src_clr[q.src] = 1'b1;
                end
                d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
        if (en_wr) d.en = en_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = (q.st != S_IDLE);
    assign src_en   = q.en;
    assign done_vec = q.vec;
endmodule

// File: rtl/vdma_ctrl_chk.sv
module vdma_ctrl_chk #(
    parameter int          N_SRC     = 4,
    parameter logic [15:0] VTAB_BASE = 16'h0400
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             mem_req,
    input logic             mem_we,
    input logic [15:0]      mem_addr,
    input logic [N_SRC-1:0] src_clr,
    input logic [N_SRC-1:0] src_en,
    input logic             en_wr,
    input logic             done_irq
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_req); // R11
    AST_VEC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_req && !mem_we && mem_addr >= VTAB_BASE && mem_addr < VTAB_BASE + 16'h0200)); // R1
    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(src_clr)); // R7
    AST_CLR_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) (|src_clr) |-> (|(src_clr & src_en))); // R9
    AST_END_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) done_irq |-> (src_clr == '0)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_irq |=> !done_irq); // R8
    AST_EN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(en_wr) && (|($past(src_en) & ~src_en))) |-> $past(done_irq)); // R8
endmodule

bind vdma_ctrl vdma_ctrl_chk #(.N_SRC(N_SRC), .VTAB_BASE(VTAB_BASE)) u_chk (
    .clk (clk), .rst_n (rst_n), .busy (busy), .mem_req (mem_req), .mem_we (mem_we),
    .mem_addr (mem_addr), .src_clr (src_clr), .src_en (src_en), .en_wr (en_wr),
    .done_irq (done_irq)
);

// File: tb/vdma_ctrl_bench.sv
module vdma_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  flags, src_clr, src_en, en_wdata;
    logic        en_wr, sw_req, busy, done_irq;
    logic [7:0]  sw_vec, done_vec;
    logic        mem_req, mem_we, mem_wide;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;

    logic [7:0]  mem [0:4095];
    int n_chk = 0, n_fail = 0;
    int done_cnt = 0, nact = 0, cur_len = 0, last_len = 0, cycles = 0;
    logic [7:0]  last_vec, act_log [0:63];
    logic [15:0] act_addr;
    logic        busy_prev = 1'b0;

    always #5 clk = ~clk;

    vdma_ctrl u_vdma_ctrl (
        .clk (clk), .rst_n (rst_n), .irq_src (flags), .src_clr (src_clr),
        .en_wr (en_wr), .en_wdata (en_wdata), .src_en (src_en),
        .sw_req (sw_req), .sw_vec (sw_vec), .busy (busy),
        .done_irq (done_irq), .done_vec (done_vec),
        .mem_req (mem_req), .mem_we (mem_we), .mem_wide (mem_wide),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
    );

    // memory and peripheral flag model
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                if (mem_wide) begin
                    mem[{mem_addr[11:1], 1'b0}] <= mem_wdata[15:8];
                    mem[{mem_addr[11:1], 1'b1}] <= mem_wdata[7:0];
                end else begin
                    mem[mem_addr[11:0]] <= mem_wdata[7:0];
                end
            end else begin
                mem_rdata <= mem_wide ? {mem[{mem_addr[11:1], 1'b0}], mem[{mem_addr[11:1], 1'b1}]}
                                      : {8'd0, mem[mem_addr[11:0]]};
            end
        end
        for (int i = 0; i < 4; i++) if (src_clr[i]) flags[i] <= 1'b0;
    end

    // monitors
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (done_irq) begin done_cnt++; last_vec = done_vec; end
            if (busy && !busy_prev) begin
                act_addr = mem_addr;
                act_log[nact[5:0]] = 8'((mem_addr - 16'h0400) >> 1);
                nact++;
            end
            if (busy) cur_len++;
            else if (busy_prev) begin last_len = cur_len; cur_len = 0; end
            busy_prev = busy;
        end
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr16(input int a, input logic [15:0] v);
        mem[a] = v[15:8]; mem[a + 1] = v[7:0];
    endtask

    function automatic logic [15:0] rd16(input int a);
        return {mem[a], mem[a + 1]};
    endfunction

    task automatic put_rec(input int a, input logic [15:0] m, input logic [15:0] c,
                           input logic [15:0] s, input logic [15:0] dd, input logic [15:0] n);
        wr16(a, m); wr16(a + 2, c); wr16(a + 4, s); wr16(a + 6, dd); wr16(a + 8, n);
    endtask

    task automatic wait_quiet();
        int quiet = 0;
        for (int k = 0; k < 2000 && quiet < 4; k++) begin
            @(negedge clk);
            quiet = busy ? 0 : quiet + 1;
        end
        if (quiet < 4) chk(1'b0, "R11 busy never fell", 1, 0);
    endtask

    task automatic run_sw(input logic [7:0] v);
        @(negedge clk); sw_req = 1'b1; sw_vec = v;
        @(negedge clk); sw_req = 1'b0;
        wait_quiet();
    endtask

    task automatic raise(input logic [3:0] m);
        @(negedge clk); flags = flags | m;
    endtask

    task automatic set_en(input logic [3:0] m);
        @(negedge clk); en_wr = 1'b1; en_wdata = m;
        @(negedge clk); en_wr = 1'b0;
    endtask

    // mode, src, dst, count, expected src, dst, count, end-of-count
    typedef struct packed {
        logic [15:0] mode, sa, da, cn, esa, eda, ecn;
        logic        fin;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{16'h8100, 16'h0A00, 16'h0C00, 16'd5, 16'h0A02, 16'h0C00, 16'd4, 1'b0},
        '{16'h2000, 16'h0A11, 16'h0C21, 16'd3, 16'h0A11, 16'h0C22, 16'd2, 1'b0},
        '{16'hF100, 16'h0A40, 16'h0C40, 16'd2, 16'h0A3E, 16'h0C3E, 16'd1, 1'b0},
        '{16'hB000, 16'h0A51, 16'h0C61, 16'd9, 16'h0A52, 16'h0C60, 16'd8, 1'b0},
        '{16'h5100, 16'h0A70, 16'h0C70, 16'd7, 16'h0A70, 16'h0C70, 16'd6, 1'b0},
        '{16'hA100, 16'h0A80, 16'h0C80, 16'd1, 16'h0A82, 16'h0C82, 16'd0, 1'b1}
    };

    initial begin
        int d0, b;
        rst_n = 1'b0; flags = '0; en_wr = 1'b0; en_wdata = '0;
        sw_req = 1'b0; sw_vec = '0; mem_rdata = '0;
        for (int i = 0; i < 4096; i++) mem[i] = 8'd0;
        for (int i = 16'h0A00; i < 16'h0B00; i++) mem[i] = 8'(i) ^ 8'h5A;
        wr16(16'h04C0, 16'h0800);
        wr16(16'h0440, 16'h0820); wr16(16'h0442, 16'h0840);
        wr16(16'h0444, 16'h0860); wr16(16'h0446, 16'h0880);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && mem_req == 1'b0, "R12 idle after reset", busy, 0);
        chk(src_en == 4'd0 && done_irq == 1'b0 && src_clr == 4'd0, "R12 enables and pulses", src_en, 0);
        rst_n = 1'b1;

        // table of single-record software activations through vector 0x60
        for (int e = 0; e < 6; e++) begin
            put_rec(16'h0800, TBL[e].mode, 16'h0000, TBL[e].sa, TBL[e].da, TBL[e].cn);
            d0 = done_cnt;
            run_sw(8'h60);
            chk(act_addr == 16'h04C0, "R1 vector address", act_addr, 16'h04C0);
            chk(rd16(16'h0804) == TBL[e].esa, "R2 source writeback", rd16(16'h0804), TBL[e].esa);
            chk(rd16(16'h0806) == TBL[e].eda, "R2 destination writeback", rd16(16'h0806), TBL[e].eda);
            chk(rd16(16'h0808) == TBL[e].ecn, "R4 count writeback", rd16(16'h0808), TBL[e].ecn);
            chk(mem[TBL[e].da] == mem[TBL[e].sa], "R3 first byte moved", mem[TBL[e].da], mem[TBL[e].sa]);
            if (TBL[e].mode[8])
                chk(mem[TBL[e].da + 1] == mem[TBL[e].sa + 1], "R3 second byte moved",
                    mem[TBL[e].da + 1], mem[TBL[e].sa + 1]);
            else
                chk(mem[TBL[e].da + 1] == 8'd0, "R3 byte size touches one byte", mem[TBL[e].da + 1], 0);
            chk(done_cnt - d0 == int'(TBL[e].fin), "R8 software end-of-count pulse", done_cnt - d0, TBL[e].fin);
            chk(last_len == 13, "R11 single record busy span", last_len, 13);
        end
        chk(last_vec == 8'h60, "R10 software vector reported", last_vec, 8'h60);

        // repeat mode on source 1: source side repeats, word size, 2-entry area
        put_rec(16'h0840, 16'h8700, 16'h0000, 16'h0A00, 16'h0C90, 16'h0202);
        set_en(4'b0010);
        d0 = done_cnt;
        raise(4'b0010); wait_quiet();
        chk(rd16(16'h0848) == 16'h0201, "R5 low byte decrements", rd16(16'h0848), 16'h0201);
        chk(rd16(16'h0844) == 16'h0A02, "R5 source steps", rd16(16'h0844), 16'h0A02);
        chk(flags[1] == 1'b0, "R7 flag cleared mid count", flags[1], 0);
        raise(4'b0010); wait_quiet();
        chk(rd16(16'h0848) == 16'h0202, "R5 count reloaded", rd16(16'h0848), 16'h0202);
        chk(rd16(16'h0844) == 16'h0A00, "R5 source area reloaded", rd16(16'h0844), 16'h0A00);
        chk(rd16(16'h0846) == 16'h0C90, "R5 fixed destination", rd16(16'h0846), 16'h0C90);
        chk(done_cnt == d0, "R5 repeat never ends", done_cnt - d0, 0);

        // linked records on source 0: first ends its count but is not last
        put_rec(16'h0820, 16'hA100, 16'h8000, 16'h0A00, 16'h0CA0, 16'd1);
        put_rec(16'h082A, 16'h8100, 16'h0000, 16'h0A10, 16'h0CB0, 16'd3);
        set_en(4'b0011);
        d0 = done_cnt;
        raise(4'b0001); wait_quiet();
        chk(rd16(16'h0828) == 16'd0, "R6 first record ran", rd16(16'h0828), 0);
        chk(rd16(16'h0832) == 16'd2, "R6 linked record ran", rd16(16'h0832), 2);
        chk(rd16(16'h082E) == 16'h0A12, "R6 linked record source", rd16(16'h082E), 16'h0A12);
        chk(last_len == 23, "R11 two record busy span", last_len, 23);
        chk(flags[0] == 1'b0 && src_en[0] == 1'b1, "R7 last record decides", {flags[0], src_en[0]}, 2'b01);
        chk(done_cnt == d0, "R7 no interrupt from inner record", done_cnt - d0, 0);

        // end of count on source 2
        put_rec(16'h0860, 16'h8100, 16'h0000, 16'h0A20, 16'h0CC0, 16'd1);
        set_en(4'b0111);
        d0 = done_cnt;
        raise(4'b0100); wait_quiet();
        chk(flags[2] == 1'b1, "R8 flag left set", flags[2], 1);
        chk(src_en == 4'b0011, "R8 enable cleared", src_en, 4'b0011);
        chk(done_cnt == d0 + 1 && last_vec == 8'h22, "R8 interrupt with vector", last_vec, 8'h22);

        // priority: flags 0,1,3 together, source 0 disabled
        put_rec(16'h0880, 16'h8100, 16'h0000, 16'h0A30, 16'h0CD0, 16'd16);
        set_en(4'b1010);
        b = nact;
        raise(4'b1011); wait_quiet();
        chk(nact == b + 2, "R9 two sources served", nact - b, 2);
        chk(act_log[b[5:0]] == 8'h21, "R9 lowest index first", act_log[b[5:0]], 8'h21);
        chk(act_log[b[5:0] + 6'd1] == 8'h23, "R9 next source second", act_log[b[5:0] + 6'd1], 8'h23);
        chk(flags[0] == 1'b1, "R9 disabled source ignored", flags[0], 1);

        // software request while busy is held
        put_rec(16'h0800, 16'h8100, 16'h0000, 16'h0A00, 16'h0CE0, 16'd4);
        @(negedge clk); flags[0] = 1'b0;
        b = nact;
        raise(4'b1000);
        @(negedge clk); @(negedge clk);
        chk(busy == 1'b1, "R11 busy during activation", busy, 1);
        sw_req = 1'b1; sw_vec = 8'h60;
        @(negedge clk); sw_req = 1'b0;
        wait_quiet();
        chk(nact == b + 2 && act_log[b[5:0] + 6'd1] == 8'h60, "R10 held request served",
            act_log[b[5:0] + 6'd1], 8'h60);
        chk(rd16(16'h0808) == 16'd3, "R10 software record count", rd16(16'h0808), 3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule